// File: doc/BRIEF.md
# Temporal Vector Instruction Sequencer

This block executes one vector arithmetic instruction by walking its elements through a single 64-bit integer lane, one element per clock. The architectural vector length (the element count `vl` supplied with the instruction) is independent of the lane width. An instruction over `vl` elements therefore occupies the lane for `vl` cycles, in the manner of a pipelined vector machine rather than a wide SIMD datapath.

The issuing core presents an opcode, a destination register, two source registers and the current `vl`, then pulses `start`. While it works, the sequencer shows `busy`. Each cycle it drives read addresses for both source elements into an external vector register array and writes the lane result back to the destination element in the same cycle. Array addresses are formed as `{register number, element index}`. When the last element has been written, it raises `done` for one cycle, together with `err` if the opcode was not recognised. Because the element count comes from `vl` on every issue, a strip-mined loop's short final pass runs through the same path with no tail code.

Top module: `vec_temporal_seq`

## Requirements
- R1: During and right after synchronous active-low reset, `busy`, `done`, `err` and `rf_we` are all 0.
- R2: A `start` pulse seen while idle with a known opcode and an effective length n ≥ 1 makes `busy` high for exactly the n following cycles, with `rf_we` high in each of them.
- R3: In the k-th busy cycle (k from 0), `rf_waddr` is `{vd, k}`, `rf_raddr_a` is `{vs1, k}` and `rf_raddr_b` is `{vs2, k}`, with the register number in the upper bits and the element index in the low log2(MAX_VL) bits.
- R4: Opcode 0 writes a+b, 1 writes a−b, 2 writes a shifted left by one bit, and 3 writes a unchanged, where a and b are the elements read at the source A and source B addresses. All arithmetic wraps modulo 2^64.
- R5: The lengths 4, 8 and 16 and any length between 1 and 16 run on the same lane, with one element per cycle and no other change of behaviour.
- R6: A `vl` above MAX_VL (16) is processed as MAX_VL elements.
- R7: A `vl` of 0 with a known opcode gives `done` in the next cycle with `busy` and `err` low, and makes no writes.
- R8: Opcodes 4 to 7 are unknown. They give `done` and `err` together in the next cycle and make no writes.
- R9: A `start` while busy is ignored: the instruction in progress keeps its fields, its length and its results.
- R10: `done` is a single-cycle pulse in the cycle after the last element write, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue pulse for a new instruction |
| op | input | 3 | Operation code |
| vd | input | 3 | Destination vector register |
| vs1 | input | 3 | Source A vector register |
| vs2 | input | 3 | Source B vector register |
| vl | input | 5 | Element count for this instruction |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unknown opcode, valid with done |
| rf_raddr_a | output | 7 | Source A element address |
| rf_raddr_b | output | 7 | Source B element address |
| rf_rdata_a | input | 64 | Source A element data (combinational read) |
| rf_rdata_b | input | 64 | Source B element data (combinational read) |
| rf_we | output | 1 | Element write enable |
| rf_waddr | output | 7 | Destination element address |
| rf_wdata | output | 64 | Result element data |

## Verification
On every cycle the assertions check the cycle-to-cycle protocol. The element index advances by one per busy cycle and stays at or below the last index. The captured fields hold still while busy. `done` never lasts two cycles, `err` appears only with `done` and never with a write, and a zero-length issue finishes at once. Only the bench's scenarios can show that the results written into the array are the right arithmetic values and that in-place operation (destination equal to a source) is handled. They also show that the clamp of oversized lengths, the exact issue-to-done latency, and the absence of side effects from a start during busy come out right end to end against a reference model of the register array.

// File: rtl/vts_pkg.sv
// Shared definitions for the temporal vector sequencer.
// Assumes opcodes are 3 bits wide; values above OP_MOV are unknown.
package vts_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_DBL = 3'd2,
        OP_MOV = 3'd3
    } vop_e;

    // True when the opcode belongs to the supported set.
    function automatic logic op_known(input logic [OP_W-1:0] code);
        return code <= OP_MOV;
    endfunction

endpackage

// File: rtl/vts_ctrl.sv
// Issue and element-step control. Accepts one instruction while idle,
// captures its fields, clamps the length and steps the element index
// once per cycle. Assumes start is a level sampled on each clock.
module vts_ctrl
    import vts_pkg::*;
#(
    parameter int MAX_VL = 16,
    parameter int REG_W  = 3,
    parameter int IDX_W  = $clog2(MAX_VL),
    parameter int VL_W   = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OP_W-1:0]  op_in,
    input  logic [REG_W-1:0] vd_in,
    input  logic [REG_W-1:0] vs1_in,
    input  logic [REG_W-1:0] vs2_in,
    input  logic [VL_W-1:0]  vl_in,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [IDX_W-1:0] idx,
    output logic [OP_W-1:0]  op_q,
    output logic [REG_W-1:0] vd_q,
    output logic [REG_W-1:0] vs1_q,
    output logic [REG_W-1:0] vs2_q
);

    logic             busy_q, done_q, err_q;
    logic [IDX_W-1:0] idx_q, last_q;
    logic [VL_W-1:0]  vl_eff;
    logic             accept, bad_op, empty;

    // Clamp the requested length and classify the issue.
    always_comb begin
        vl_eff = (vl_in > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_in;
        accept = start && !busy_q;
        bad_op = !op_known(op_in);
        empty  = (vl_eff == '0);
    end

    // Issue, element stepping and completion state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
            op_q   <= '0;
            vd_q   <= '0;
            vs1_q  <= '0;
            vs2_q  <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (busy_q) begin
                if (idx_q == last_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end else if (accept) begin
                if (bad_op || empty) begin
                    done_q <= 1'b1;
                    err_q  <= bad_op;
                end else begin
                    busy_q <= 1'b1;
                    idx_q  <= '0;
                    last_q <= IDX_W'(vl_eff - 1'b1);
                    op_q   <= op_in;
                    vd_q   <= vd_in;
                    vs1_q  <= vs1_in;
                    vs2_q  <= vs2_in;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign err  = err_q;
    assign idx  = idx_q;

    // R3: the index advances by exactly one per consecutive busy cycle.
    p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> (idx_q == $past(idx_q) + 1'b1));

    // R5: the index never passes the last element of the instruction.
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (idx_q <= last_q));

    // R9: captured fields hold for the whole instruction.
    p_fields_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(vd_q) && $stable(vs1_q)
                                       && $stable(vs2_q) && $stable(op_q)
                                       && $stable(last_q)));

    // R10: done never lasts more than one cycle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/vts_addr.sv
// Element address formation. Each address is {register, element index};
// the read ports are built by a generate loop over the source count.
module vts_addr #(
    parameter int REG_W  = 3,
    parameter int IDX_W  = 4,
    parameter int N_SRC  = 2,
    parameter int ADDR_W = REG_W + IDX_W
) (
    input  logic [IDX_W-1:0]             idx,
    input  logic [REG_W-1:0]             dst_reg,
    input  logic [N_SRC-1:0][REG_W-1:0]  src_reg,
    output logic [ADDR_W-1:0]            waddr,
    output logic [N_SRC-1:0][ADDR_W-1:0] raddr
);

    // Destination element address.
    assign waddr = {dst_reg, idx};

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        // Source element address for read port s.
        assign raddr[s] = {src_reg[s], idx};
    end

endmodule

// File: rtl/vts_lane.sv
// Single integer execution lane, combinational. Computes one element
// result from two source elements; unknown opcodes yield zero (the
// controller never writes in that case).
module vts_lane
    import vts_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);

    // Operation select; all arithmetic wraps at DATA_W bits.
    always_comb begin
        case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_DBL:  res = {a[DATA_W-2:0], 1'b0};
            OP_MOV:  res = a;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/vec_temporal_seq.sv
// Temporal vector instruction sequencer top. Runs vl elements of one
// vector instruction through a single lane, one per cycle, reading and
// writing an external register array whose read is combinational.
module vec_temporal_seq
    import vts_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_VREG = 8,
    parameter int MAX_VL   = 16,
    parameter int REG_W    = $clog2(NUM_VREG),
    parameter int IDX_W    = $clog2(MAX_VL),
    parameter int VL_W     = $clog2(MAX_VL + 1),
    parameter int ADDR_W   = REG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [REG_W-1:0]  vd,
    input  logic [REG_W-1:0]  vs1,
    input  logic [REG_W-1:0]  vs2,
    input  logic [VL_W-1:0]   vl,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] rf_raddr_a,
    output logic [ADDR_W-1:0] rf_raddr_b,
    input  logic [DATA_W-1:0] rf_rdata_a,
    input  logic [DATA_W-1:0] rf_rdata_b,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);

    localparam int N_SRC = 2;

    logic [IDX_W-1:0]             idx;
    logic [OP_W-1:0]              op_q;
    logic [REG_W-1:0]             vd_q, vs1_q, vs2_q;
    logic [N_SRC-1:0][REG_W-1:0]  src_regs;
    logic [N_SRC-1:0][ADDR_W-1:0] raddrs;

    vts_ctrl #(
        .MAX_VL (MAX_VL),
        .REG_W  (REG_W),
        .IDX_W  (IDX_W),
        .VL_W   (VL_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op_in  (op),
        .vd_in  (vd),
        .vs1_in (vs1),
        .vs2_in (vs2),
        .vl_in  (vl),
        .busy   (busy),
        .done   (done),
        .err    (err),
        .idx    (idx),
        .op_q   (op_q),
        .vd_q   (vd_q),
        .vs1_q  (vs1_q),
        .vs2_q  (vs2_q)
    );

    assign src_regs = {vs2_q, vs1_q};

    vts_addr #(
        .REG_W  (REG_W),
        .IDX_W  (IDX_W),
        .N_SRC  (N_SRC),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .idx     (idx),
        .dst_reg (vd_q),
        .src_reg (src_regs),
        .waddr   (rf_waddr),
        .raddr   (raddrs)
    );

    assign rf_raddr_a = raddrs[0];
    assign rf_raddr_b = raddrs[1];

    vts_lane #(
        .DATA_W (DATA_W)
    ) u_lane (
        .op  (op_q),
        .a   (rf_rdata_a),
        .b   (rf_rdata_b),
        .res (rf_wdata)
    );

    // One element is written in every busy cycle.
    assign rf_we = busy;

    // R7: an empty instruction completes in the next cycle without going busy.
    p_empty_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_known(op) && (vl == '0)) |=> (done && !busy && !err));

    // R8: an error is only reported with done and never with a write.
    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !rf_we));

    // R10: completion never overlaps an element write.
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/vec_temporal_seq_tb.sv
// Bench: behavioural register array, cycle reference model compared on
// every clock, and a golden array checked after each instruction.
module vec_temporal_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 64;
    localparam int NREG  = 8;
    localparam int MVL   = 16;
    localparam int RW    = 3;
    localparam int IW    = 4;
    localparam int AW    = RW + IW;
    localparam int DEPTH = NREG * MVL;
    localparam int WDOG  = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    op = '0;
    logic [RW-1:0] vd = '0, vs1 = '0, vs2 = '0;
    logic [4:0]    vl = '0;
    logic          busy, done, err, rf_we;
    logic [AW-1:0] rf_raddr_a, rf_raddr_b, rf_waddr;
    logic [DW-1:0] rf_rdata_a, rf_rdata_b, rf_wdata;

    logic [DW-1:0] rf   [DEPTH];
    logic [DW-1:0] gold [DEPTH];

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_temporal_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vd(vd),
        .vs1(vs1), .vs2(vs2), .vl(vl), .busy(busy), .done(done), .err(err),
        .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
        .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    // Behavioural register array: combinational read, clocked write.
    assign rf_rdata_a = rf[rf_raddr_a];
    assign rf_rdata_b = rf[rf_raddr_b];
    always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

    function automatic logic [DW-1:0] ref_op(input int code, input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
        case (code)
            0: return a + b;
            1: return a - b;
            2: return a * 2;
            default: return a;
        endcase
    endfunction

    // Cycle reference model of the sequencer's visible behaviour.
    int m_busy = 0, m_done = 0, m_err = 0, m_idx = 0, m_last = 0;
    int m_op = 0, m_vd = 0, m_vs1 = 0, m_vs2 = 0;
    int eff_len;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_err <= 0; m_idx <= 0;
        end else begin
            m_done <= 0;
            m_err  <= 0;
            if (m_busy != 0) begin
                if (m_idx == m_last) begin
                    m_busy <= 0;
                    m_done <= 1;
                end else begin
                    m_idx <= m_idx + 1;
                end
            end else if (start) begin
                eff_len = (int'(vl) > MVL) ? MVL : int'(vl);
                if (int'(op) > 3 || eff_len == 0) begin
                    m_done <= 1;
                    m_err  <= (int'(op) > 3) ? 1 : 0;
                end else begin
                    m_busy <= 1;
                    m_idx  <= 0;
                    m_last <= eff_len - 1;
                    m_op <= int'(op); m_vd <= int'(vd); m_vs1 <= int'(vs1); m_vs2 <= int'(vs2);
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        logic [AW-1:0] ea, eb, ew;
        logic [DW-1:0] ed;
        cycles++;
        tests++;
        if (!rst_n) begin
            if (busy || done || err || rf_we) begin
                fails++;
                $display("FAIL R1 reset outputs busy=%0b done=%0b err=%0b we=%0b expected all 0",
                         busy, done, err, rf_we);
            end
        end else begin
            ew = AW'(m_vd * MVL + m_idx);
            ea = AW'(m_vs1 * MVL + m_idx);
            eb = AW'(m_vs2 * MVL + m_idx);
            ed = ref_op(m_op, rf[ea], rf[eb]);
            if (busy !== (m_busy != 0) || done !== (m_done != 0) || err !== (m_err != 0)
                || rf_we !== (m_busy != 0)) begin
                fails++;
                $display("FAIL R2/R10 status busy=%0b done=%0b err=%0b we=%0b expected %0d %0d %0d %0d",
                         busy, done, err, rf_we, m_busy, m_done, m_err, m_busy);
            end else if (m_busy != 0 && (rf_waddr !== ew || rf_raddr_a !== ea || rf_raddr_b !== eb)) begin
                fails++;
                $display("FAIL R3 addr w=%0h a=%0h b=%0h expected %0h %0h %0h",
                         rf_waddr, rf_raddr_a, rf_raddr_b, ew, ea, eb);
            end else if (m_busy != 0 && rf_wdata !== ed) begin
                fails++;
                $display("FAIL R4 wdata=%0h expected %0h", rf_wdata, ed);
            end
        end
    end

    // Whole-array comparison with the golden copy.
    task automatic check_rf(input string tag);
        int bad = -1;
        for (int i = 0; i < DEPTH; i++) if (bad < 0 && rf[i] !== gold[i]) bad = i;
        tests++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s array[%0d]=%0h expected %0h", tag, bad, rf[bad], gold[bad]);
        end
    endtask

    // Issue one instruction, optionally injecting a start while busy.
    task automatic issue(input int c, input int d, input int s1, input int s2,
                         input int len, input bit inject, input string tag);
        int eff = (len > MVL) ? MVL : len;
        int n;
        if (c <= 3)
            for (int k = 0; k < eff; k++)
                gold[d*MVL + k] = ref_op(c, gold[s1*MVL + k], gold[s2*MVL + k]);
        @(negedge clk);
        start = 1'b1; op = 3'(c); vd = RW'(d); vs1 = RW'(s1); vs2 = RW'(s2); vl = 5'(len);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 100) begin
            if (inject && n == 3) begin
                start = 1'b1; op = 3'd1; vd = RW'(s1); vs1 = RW'(d); vs2 = RW'(d); vl = 5'd2;
            end
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        tests++;
        if (n != ((c > 3) ? 1 : eff + 1) || err !== (c > 3)) begin
            fails++;
            $display("FAIL %s latency=%0d err=%0b expected %0d %0b", tag, n, err,
                     (c > 3) ? 1 : eff + 1, (c > 3));
        end
        check_rf(tag);
    endtask

    // Watchdog: an overrun counts as a failure and still reports.
    always @(posedge clk) if (cycles > WDOG) begin
        fails++;
        $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            rf[i]   = (64'h9E37_79B9_7F4A_7C15 * 64'(i + 3)) ^ (64'(i) << 40);
            gold[i] = rf[i];
        end
        rf[7*MVL] = '1;          gold[7*MVL] = '1;       // for wrap on add
        rf[6*MVL] = 64'd1;       gold[6*MVL] = 64'd1;
        rf[5*MVL] = 64'd0;       gold[5*MVL] = 64'd0;    // for wrap on sub
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_rf("R1");
        issue(0, 2, 7, 6, 4,  1'b0, "R4 add len4 R5");
        issue(1, 3, 5, 6, 8,  1'b0, "R4 sub len8 R5");
        issue(2, 4, 1, 0, 16, 1'b0, "R4 dbl len16 R5");
        issue(3, 0, 3, 3, 7,  1'b0, "R5 mov partial len7");
        issue(2, 1, 1, 1, 5,  1'b0, "R4 dbl in place");
        issue(0, 6, 2, 3, 20, 1'b0, "R6 clamp len20");
        issue(0, 4, 2, 3, 0,  1'b0, "R7 empty");
        issue(5, 4, 2, 3, 8,  1'b0, "R8 unknown op5");
        issue(7, 0, 1, 1, 16, 1'b0, "R8 unknown op7");
        issue(0, 5, 6, 7, 8,  1'b1, "R9 start while busy");
        issue(1, 7, 4, 2, 1,  1'b0, "R10 single element");
        issue(3, 2, 5, 5, 16, 1'b0, "R2 back to back");
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule